// File: doc/BRIEF.md
# Privileged Control Register Bank

The block holds the 64-bit internal control registers of a processor core. Privileged move instructions reach them through one 6-bit index, a read strobe and a write strobe. Each register has its own rule. Most keep only a subset of the written bits. Some clear themselves on any write. Some are read-only and some are write-only. A read of one register releases an interrupt-status lock.

Writes to the translation-buffer invalidate registers act as commands. Invalidate-all and invalidate-process store zero and raise a one-cycle request on the matching output. Single-address invalidate keeps the written value and raises a request that carries the address. A separate set of requests exists for the data side and for the instruction side.

An illegal access raises `fault` in the same cycle and aborts the whole access. Reads are combinational. Writes land at the rising clock edge.

Top module: `ipr_bank`

## Requirements
- R1: After reset every register reads zero, with two exceptions. The firmware base (index 24) holds parameter `FW_BASE_RESET`. The machine control register (index 42) holds 0x6.
- R2: A write keeps only some bits in these registers; every other bit is stored as zero:
  - index 25 (exception restart address) keeps all bits except bit 1
  - indices 26 and 27 keep bits 3:0
  - index 28 keeps bits 4:0
  - indices 29 and 30 keep mask 0x18
  - index 31 keeps mask 0x7FFF0
  - index 32 keeps mask 0xFFFFFF0300
  - indices 33 and 34 keep mask 0xFFFFFFFFC0000000
  - indices 35 and 36 keep mask 0x3F
  - index 37 keeps mask 0x1FFB
  - index 38 keeps mask 0x7F0
  - index 39 keeps mask 0xFE00000000000000
- R3: Scratch registers (indices 0 to 23), the firmware base (24) and machine control (42) store all 64 written bits.
- R4: Any write to index 40 or index 41 sets that register to zero, whatever the write data.
- R5: A write to indices 43 to 48 raises `fault` and changes no register. These are interrupt ID, serial receive, memory status, the two page-entry temporaries and the faulting virtual address.
- R6: A read of a write-only register raises `fault` and returns zero on `rdData`. The write-only registers are index 30 and indices 49 to 58.
- R7: Indices 59 to 63 are unassigned. Any read or write to them raises `fault` and changes nothing.
- R8: Write-only indices 53, 54, 56 and 57 each store zero when written. In the cycle after an accepted write, they pulse `dInvAll`, `dInvProc`, `iInvAll` and `iInvProc` respectively for exactly one cycle.
- R9: An accepted write to index 55 or index 58 stores the data. In the next cycle it pulses `dInvOne` or `iInvOne` respectively, with `invAddr` equal to the written data.
- R10: `lockSet` sets `statusLocked` at the edge. A non-faulting read of index 48 clears it. When both occur in the same cycle, the set wins.
- R11: A read in the same cycle as an accepted write to the same index returns the value from before the write. The new value is visible from the next cycle on.
- R12: `fault` is combinational and stays low for legal accesses. A fault in either direction aborts both the read (`rdData` zero) and the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idx | input | 6 | Register index for the access |
| wrData | input | 64 | Write data |
| rdStb | input | 1 | Read request this cycle |
| wrStb | input | 1 | Write request this cycle |
| lockSet | input | 1 | Sets the interrupt-status lock |
| rdData | output | 64 | Read data, zero when not reading or faulting |
| fault | output | 1 | Illegal access in this cycle |
| statusLocked | output | 1 | Interrupt-status lock flag |
| dInvAll | output | 1 | Data-side invalidate-all request |
| dInvProc | output | 1 | Data-side invalidate-process request |
| dInvOne | output | 1 | Data-side single-address invalidate request |
| iInvAll | output | 1 | Instruction-side invalidate-all request |
| iInvProc | output | 1 | Instruction-side invalidate-process request |
| iInvOne | output | 1 | Instruction-side single-address invalidate request |
| invAddr | output | 64 | Address carried by a single-address invalidate |

## Verification
The bench builds the bank with `FW_BASE_RESET` set to a value that is not the default, with bits in both halves of the word. The reset check therefore shows that the firmware base comes from the parameter and not from a constant. The fixed 6-bit index lets random traffic cover every index, including the unassigned top five. Accesses with both strobes set mix read faults with write faults, which exercises the abort rule, the same-cycle old-value read and the set-wins lock ordering.

// File: rtl/ipr_bank_pkg.sv
package ipr_bank_pkg;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 64;
  localparam int NUM_IDX  = 1 << IDX_W;
  localparam int NUM_REGS = 59;

  localparam logic [IDX_W-1:0] SCRATCH_END  = 6'd24;
  localparam logic [IDX_W-1:0] IDX_FWBASE   = 6'd24;
  localparam logic [IDX_W-1:0] IDX_EXCADDR  = 6'd25;
  localparam logic [IDX_W-1:0] IDX_ASTREQ   = 6'd26;
  localparam logic [IDX_W-1:0] IDX_ASTEN    = 6'd27;
  localparam logic [IDX_W-1:0] IDX_IPL      = 6'd28;
  localparam logic [IDX_W-1:0] IDX_CURMODE  = 6'd29;
  localparam logic [IDX_W-1:0] IDX_ALTMODE  = 6'd30;
  localparam logic [IDX_W-1:0] IDX_SWINT    = 6'd31;
  localparam logic [IDX_W-1:0] IDX_ICTRL    = 6'd32;
  localparam logic [IDX_W-1:0] IDX_IPTBASE  = 6'd33;
  localparam logic [IDX_W-1:0] IDX_DPTBASE  = 6'd34;
  localparam logic [IDX_W-1:0] IDX_CMODE    = 6'd35;
  localparam logic [IDX_W-1:0] IDX_MAFMODE  = 6'd36;
  localparam logic [IDX_W-1:0] IDX_CTEST    = 6'd37;
  localparam logic [IDX_W-1:0] IDX_IASN     = 6'd38;
  localparam logic [IDX_W-1:0] IDX_DASN     = 6'd39;
  localparam logic [IDX_W-1:0] IDX_EXCSUM   = 6'd40;
  localparam logic [IDX_W-1:0] IDX_EXCMSK   = 6'd41;
  localparam logic [IDX_W-1:0] IDX_MCTL     = 6'd42;
  localparam logic [IDX_W-1:0] IDX_INTID    = 6'd43;
  localparam logic [IDX_W-1:0] IDX_SRCV     = 6'd44;
  localparam logic [IDX_W-1:0] IDX_MSTAT    = 6'd45;
  localparam logic [IDX_W-1:0] IDX_IPTETMP  = 6'd46;
  localparam logic [IDX_W-1:0] IDX_DPTETMP  = 6'd47;
  localparam logic [IDX_W-1:0] IDX_FVA      = 6'd48;
  localparam logic [IDX_W-1:0] IDX_HWCLR    = 6'd49;
  localparam logic [IDX_W-1:0] IDX_SXMIT    = 6'd50;
  localparam logic [IDX_W-1:0] IDX_DFLUSH   = 6'd51;
  localparam logic [IDX_W-1:0] IDX_IFLUSH   = 6'd52;
  localparam logic [IDX_W-1:0] IDX_DINVALL  = 6'd53;
  localparam logic [IDX_W-1:0] IDX_DINVPROC = 6'd54;
  localparam logic [IDX_W-1:0] IDX_DINVONE  = 6'd55;
  localparam logic [IDX_W-1:0] IDX_IINVALL  = 6'd56;
  localparam logic [IDX_W-1:0] IDX_IINVPROC = 6'd57;
  localparam logic [IDX_W-1:0] IDX_IINVONE  = 6'd58;

  typedef struct packed {
    logic              canRead;
    logic              canWrite;
    logic              zeroOnWrite;
    logic [DATA_W-1:0] keepMask;
  } accessRule_t;

  typedef enum logic [1:0] {INV_NONE, INV_ALL, INV_PROC, INV_ONE} invKind_t;

  typedef struct packed {
    logic     wrEn;
    logic     rdEn;
    logic     lockClr;
    invKind_t invKind;
    logic     invInstr;
  } iprStrobes_t;

  function automatic accessRule_t ruleOf(input logic [IDX_W-1:0] idx);
    accessRule_t r;
    r.canRead     = 1'b1;
    r.canWrite    = 1'b1;
    r.zeroOnWrite = 1'b0;
    r.keepMask    = '1;
    if (idx < SCRATCH_END) return r;
    case (idx)
      IDX_FWBASE, IDX_MCTL: ;
      IDX_EXCADDR:              r.keepMask = ~64'h2;
      IDX_ASTREQ, IDX_ASTEN:    r.keepMask = 64'hF;
      IDX_IPL:                  r.keepMask = 64'h1F;
      IDX_CURMODE:              r.keepMask = 64'h18;
      IDX_ALTMODE: begin
        r.keepMask = 64'h18;
        r.canRead  = 1'b0;
      end
      IDX_SWINT:                r.keepMask = 64'h7FFF0;
      IDX_ICTRL:                r.keepMask = 64'hFF_FFFF_0300;
      IDX_IPTBASE, IDX_DPTBASE: r.keepMask = 64'hFFFF_FFFF_C000_0000;
      IDX_CMODE, IDX_MAFMODE:   r.keepMask = 64'h3F;
      IDX_CTEST:                r.keepMask = 64'h1FFB;
      IDX_IASN:                 r.keepMask = 64'h7F0;
      IDX_DASN:                 r.keepMask = 64'hFE00_0000_0000_0000;
      IDX_EXCSUM, IDX_EXCMSK:   r.zeroOnWrite = 1'b1;
      IDX_INTID, IDX_SRCV, IDX_MSTAT, IDX_IPTETMP, IDX_DPTETMP, IDX_FVA:
        r.canWrite = 1'b0;
      IDX_HWCLR, IDX_SXMIT, IDX_DFLUSH, IDX_IFLUSH, IDX_DINVONE, IDX_IINVONE:
        r.canRead = 1'b0;
      IDX_DINVALL, IDX_DINVPROC, IDX_IINVALL, IDX_IINVPROC: begin
        r.canRead     = 1'b0;
        r.zeroOnWrite = 1'b1;
      end
      default: begin
        r.canRead  = 1'b0;
        r.canWrite = 1'b0;
      end
    endcase
    return r;
  endfunction

  function automatic logic readAllowed(input logic [IDX_W-1:0] idx);
    accessRule_t r;
    r = ruleOf(idx);
    return r.canRead;
  endfunction

  function automatic logic writeAllowed(input logic [IDX_W-1:0] idx);
    accessRule_t r;
    r = ruleOf(idx);
    return r.canWrite;
  endfunction
endpackage

// File: rtl/ipr_bank_ctrl.sv
module ipr_bank_ctrl
  import ipr_bank_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             rdStb,
  input  logic             wrStb,
  output logic             fault,
  output iprStrobes_t      strb
);
  logic rdBad, wrBad;

  assign rdBad = rdStb && !readAllowed(idx);
  assign wrBad = wrStb && !writeAllowed(idx);
  assign fault = rdBad || wrBad;

  always_comb begin
    strb          = '0;
    strb.wrEn     = wrStb && !fault;
    strb.rdEn     = rdStb && !fault;
    strb.lockClr  = strb.rdEn && (idx == IDX_FVA);
    strb.invKind  = INV_NONE;
    strb.invInstr = 1'b0;
    if (strb.wrEn) begin
      case (idx)
        IDX_DINVALL:  strb.invKind = INV_ALL;
        IDX_DINVPROC: strb.invKind = INV_PROC;
        IDX_DINVONE:  strb.invKind = INV_ONE;
        IDX_IINVALL:  begin strb.invKind = INV_ALL;  strb.invInstr = 1'b1; end
        IDX_IINVPROC: begin strb.invKind = INV_PROC; strb.invInstr = 1'b1; end
        IDX_IINVONE:  begin strb.invKind = INV_ONE;  strb.invInstr = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipr_bank_dp.sv
module ipr_bank_dp
  import ipr_bank_pkg::*;
#(
  parameter logic [DATA_W-1:0] FW_BASE_RESET = 64'h4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lockSet,
  input  iprStrobes_t       strb,
  output logic [DATA_W-1:0] rdData,
  output logic              statusLocked,
  output logic [5:0]        invPulse,
  output logic [DATA_W-1:0] invAddr
);
  logic [DATA_W-1:0] regVal [NUM_IDX];

  for (genvar i = 0; i < NUM_IDX; i++) begin : gReg
    if (i < NUM_REGS) begin : gLive
      localparam accessRule_t RL = ruleOf(IDX_W'(i));
      localparam logic [DATA_W-1:0] RST_VAL =
        (IDX_W'(i) == IDX_FWBASE) ? FW_BASE_RESET :
        (IDX_W'(i) == IDX_MCTL)   ? 64'h6 : 64'h0;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN) q <= RST_VAL;
        else if (RL.canWrite && strb.wrEn && idx == IDX_W'(i))
          q <= RL.zeroOnWrite ? '0 : (wrData & RL.keepMask);
      end
      assign regVal[i] = q;
    end else begin : gHole
      assign regVal[i] = '0;
    end
  end

  assign rdData = strb.rdEn ? regVal[idx] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusLocked <= 1'b0;
    else if (lockSet) statusLocked <= 1'b1;
    else if (strb.lockClr) statusLocked <= 1'b0;
  end

  // pulse order: dAll, dProc, dOne, iAll, iProc, iOne
  always_ff @(posedge clk) begin
    if (!rstN) begin
      invPulse <= '0;
      invAddr  <= '0;
    end else begin
      invPulse <= {strb.invKind == INV_ALL  && !strb.invInstr,
                   strb.invKind == INV_PROC && !strb.invInstr,
                   strb.invKind == INV_ONE  && !strb.invInstr,
                   strb.invKind == INV_ALL  &&  strb.invInstr,
                   strb.invKind == INV_PROC &&  strb.invInstr,
                   strb.invKind == INV_ONE  &&  strb.invInstr};
      if (strb.invKind == INV_ONE) invAddr <= wrData;
    end
  end

  assert_excaddr_bit1_R2: assert property (@(posedge clk) disable iff (!rstN)
    regVal[IDX_EXCADDR][1] == 1'b0);
  assert_ipl_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    regVal[IDX_IPL][DATA_W-1:5] == '0);
  assert_inv_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(invPulse));
  assert_inv_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.invKind != INV_NONE |=> invPulse != '0);
endmodule

// File: rtl/ipr_bank.sv
module ipr_bank
  import ipr_bank_pkg::*;
#(
  parameter logic [63:0] FW_BASE_RESET = 64'h4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  idx,
  input  logic [63:0] wrData,
  input  logic        rdStb,
  input  logic        wrStb,
  input  logic        lockSet,
  output logic [63:0] rdData,
  output logic        fault,
  output logic        statusLocked,
  output logic        dInvAll,
  output logic        dInvProc,
  output logic        dInvOne,
  output logic        iInvAll,
  output logic        iInvProc,
  output logic        iInvOne,
  output logic [63:0] invAddr
);
  iprStrobes_t strb;
  logic [5:0]  invPulse;

  ipr_bank_ctrl ctrl_i (
    .idx(idx), .rdStb(rdStb), .wrStb(wrStb), .fault(fault), .strb(strb)
  );

  ipr_bank_dp #(.FW_BASE_RESET(FW_BASE_RESET)) dp_i (
    .clk(clk), .rstN(rstN), .idx(idx), .wrData(wrData), .lockSet(lockSet),
    .strb(strb), .rdData(rdData), .statusLocked(statusLocked),
    .invPulse(invPulse), .invAddr(invAddr)
  );

  assign {dInvAll, dInvProc, dInvOne, iInvAll, iInvProc, iInvOne} = invPulse;

  assert_fault_blocks_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !strb.wrEn && !strb.rdEn);
  assert_unknown_faults_R7: assert property (@(posedge clk) disable iff (!rstN)
    (idx >= 6'd59) && (rdStb || wrStb) |-> fault);
  assert_lock_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.lockClr && !lockSet |=> !statusLocked);
  assert_lock_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    lockSet |=> statusLocked);
endmodule

// File: tb/ipr_bank_tb_top.sv
module ipr_bank_tb_top;
  localparam logic [63:0] FW_RST = 64'h0000_00A5_0001_C000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  idx = '0;
  logic [63:0] wrData = '0;
  logic        rdStb = 1'b0, wrStb = 1'b0, lockSet = 1'b0;
  logic [63:0] rdData, invAddr;
  logic        fault, statusLocked;
  logic        dInvAll, dInvProc, dInvOne, iInvAll, iInvProc, iInvOne;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] model [64];
  logic        lockM;

  always #10 clk = ~clk;

  ipr_bank #(.FW_BASE_RESET(FW_RST)) dut_i (
    .clk(clk), .rstN(rstN), .idx(idx), .wrData(wrData), .rdStb(rdStb),
    .wrStb(wrStb), .lockSet(lockSet), .rdData(rdData), .fault(fault),
    .statusLocked(statusLocked), .dInvAll(dInvAll), .dInvProc(dInvProc),
    .dInvOne(dInvOne), .iInvAll(iInvAll), .iInvProc(iInvProc),
    .iInvOne(iInvOne), .invAddr(invAddr)
  );

  function automatic logic [63:0] keepOf(input int i);
    case (i)
      25: return ~64'h2;
      26, 27: return 64'hF;
      28: return 64'h1F;
      29, 30: return 64'h18;
      31: return 64'h7FFF0;
      32: return 64'hFF_FFFF_0300;
      33, 34: return 64'hFFFF_FFFF_C000_0000;
      35, 36: return 64'h3F;
      37: return 64'h1FFB;
      38: return 64'h7F0;
      39: return 64'hFE00_0000_0000_0000;
      40, 41, 53, 54, 56, 57: return 64'h0;
      default: return '1;
    endcase
  endfunction

  function automatic bit canRd(input int i);
    return (i <= 48) && (i != 30);
  endfunction

  function automatic bit canWr(input int i);
    return (i <= 42) || (i >= 49 && i <= 58);
  endfunction

  function automatic string tagOf(input int i, input bit wasWr);
    if (i >= 59) return "R7";
    if (i >= 43 && i <= 48 && wasWr) return "R5";
    if (i == 30 || i >= 49) return "R6";
    if (i < 25 || i == 42) return "R3";
    if (i == 40 || i == 41) return "R4";
    return "R2";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int i, input logic [63:0] d, input bit rd,
                      input bit wr, input bit ls);
    bit expFault;
    logic [63:0] expRd;
    logic [5:0] expPulse, gotPulse;
    @(negedge clk);
    idx = 6'(i); wrData = d; rdStb = rd; wrStb = wr; lockSet = ls;
    #2;
    expFault = (rd && !canRd(i)) || (wr && !canWr(i));
    expRd = (rd && !expFault) ? model[i] : 64'h0;
    check(fault == expFault, expFault ? tagOf(i, wr && !canWr(i)) : "R12",
          "fault", {63'h0, fault}, {63'h0, expFault});
    if (rd)
      check(rdData == expRd, (wr && !expFault) ? "R11" : tagOf(i, 1'b0),
            "rdData", rdData, expRd);
    expPulse = '0;
    if (wr && !expFault) begin
      model[i] = d & keepOf(i);
      case (i)
        53: expPulse = 6'b100000;
        54: expPulse = 6'b010000;
        55: expPulse = 6'b001000;
        56: expPulse = 6'b000100;
        57: expPulse = 6'b000010;
        58: expPulse = 6'b000001;
        default: ;
      endcase
    end
    if (ls) lockM = 1'b1;
    else if (rd && !expFault && i == 48) lockM = 1'b0;
    @(posedge clk);
    #1;
    rdStb = 0; wrStb = 0; lockSet = 0;
    gotPulse = {dInvAll, dInvProc, dInvOne, iInvAll, iInvProc, iInvOne};
    check(gotPulse == expPulse, (expPulse[3] || expPulse[0]) ? "R9" : "R8",
          "invalidate pulses", {58'h0, gotPulse}, {58'h0, expPulse});
    if (expPulse[3] || expPulse[0])
      check(invAddr == d, "R9", "invAddr", invAddr, d);
    check(statusLocked == lockM, "R10", "statusLocked",
          {63'h0, statusLocked}, {63'h0, lockM});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    model[24] = FW_RST;
    model[42] = 64'h6;
    lockM = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset values, read through every index
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      idx = 6'(i); rdStb = canRd(i); #2;
      if (canRd(i))
        check(rdData == model[i], "R1", "reset value", rdData, model[i]);
      rdStb = 0;
    end

    // R2: masked fields with all ones
    for (int i = 25; i <= 39; i++) begin
      step(i, '1, 1'b0, 1'b1, 1'b0);
      if (i != 30) step(i, '0, 1'b1, 1'b0, 1'b0);
    end
    // R4: clear on write
    step(40, 64'hDEAD, 1'b0, 1'b1, 1'b0);
    step(40, '0, 1'b1, 1'b0, 1'b0);
    // R11: read old value during a write
    step(5, 64'h1111_2222_3333_4444, 1'b0, 1'b1, 1'b0);
    step(5, 64'h5555_6666_7777_8888, 1'b1, 1'b1, 1'b0);
    step(5, '0, 1'b1, 1'b0, 1'b0);
    // R5: read-only write with read set aborts both
    step(44, 64'hFFFF, 1'b1, 1'b1, 1'b0);
    // R10: lock set, clear, set wins, faulted read leaves it
    step(48, '0, 1'b0, 1'b0, 1'b1);
    step(48, '0, 1'b1, 1'b0, 1'b0);
    step(48, '0, 1'b1, 1'b0, 1'b1);
    step(48, '0, 1'b1, 1'b1, 1'b0);
    // R8 R9: each invalidate command
    for (int i = 53; i <= 58; i++) step(i, 64'hABCD_0000_1234_5678 + 64'(i), 1'b0, 1'b1, 1'b0);
    // R7: unassigned indices
    step(61, '1, 1'b1, 1'b1, 1'b0);

    void'($urandom(32'h5EED));
    for (int n = 0; n < 4000; n++) begin
      step(int'($urandom % 64), {$urandom, $urandom}, 1'($urandom), 1'($urandom),
           ($urandom % 8) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule